// File: doc/BRIEF.md
# Bus Watchpoint Comparator Bank

This block watches every CPU bus cycle and reports, one clock later, which of its four watchpoints the cycle satisfied. Each bus cycle carries an address, a data word, a direction (read or write) and an access size (byte or word). The four comparators are grouped in two pairs. The first member of each pair (comparators 0 and 2, the "full" comparators) checks both the address and the data, and the data compare can be masked bit by bit. The second member of each pair (comparators 1 and 3, the "address" comparators) ignores data but can be restricted to byte or word accesses. Every comparator can be restricted to reads, to writes, or to either.

A full comparator can also be switched into a range mode. It then takes its own address as the lower bound and its partner's address as the upper bound, and it reports on its own match line whether the bus address falls inside or outside that span. The partner keeps running its own exact compare at the same time.

Configuration goes through a plain write port that selects a comparator and a field. Each match line is a registered pulse. It is high for exactly the one cycle that follows a qualifying bus cycle.

The block has no sequential control, so it has no state machine. Its named "states" are the per-comparator operating modes:

- **Exact**: compare the address, plus the masked data on full comparators.
- **Inside**: match when min ≤ address ≤ max.
- **Outside**: match when address < min or address > max.

The only transitions are register writes. A write to a control field moves a comparator between disabled and enabled, and between exact, inside and outside.

Top module: `wpt_bank`

## Requirements
- R1: After reset every comparator is disabled and all of `match` is 0.
- R2: `match` is registered. A bus cycle sampled at clock edge t drives `match` during the cycle after edge t. When `bus_valid` is 0, that following cycle has `match` equal to 0, whatever the other bus inputs are.
- R3: While a comparator's enable bit (control bit 0) is 0, its match bit stays 0.
- R4: A full comparator (index 0 or 2) in exact mode requires two things. First, `bus_addr` must equal its address field. Second, `(bus_data ^ data_field) & mask_field` must be 0, so only the bits whose mask bit is 1 are compared.
- R5: An address comparator (index 1 or 3) matches on the address alone, and `bus_data` has no effect on it.
- R6: The direction field is control bits [2:1]. The value 1 matches only reads (`bus_rnw`=1). The value 2 matches only writes. The values 0 and 3 match either direction.
- R7: The size field is control bits [6:5] and applies to address comparators only. The value 1 matches only byte cycles (`bus_byte`=1). The value 2 matches only word cycles. The values 0 and 3 match either size. `bus_byte` has no effect on full comparators.
- R8: Mode field control bits [4:3] = 1 selects inside mode on a full comparator. It matches when own address ≤ `bus_addr` ≤ partner address, with both bounds inclusive. The partner of comparator 0 is comparator 1, and the partner of comparator 2 is comparator 3. The result appears on the full comparator's match bit, and the data is not compared. Mode values 0 and 3 select exact mode.
- R9: Mode field = 2 selects outside mode on a full comparator. It matches when `bus_addr` < own address or `bus_addr` > partner address.
- R10: A write with `cfg_we`=1 stores `cfg_wdata` into the field `cfg_field` of comparator `cfg_cmp`. The field codes are 0 = control, 1 = address, 2 = data value, 3 = data mask. The stored value governs bus cycles sampled at later edges.
- R11: While a full comparator is in a range mode, its partner keeps matching on its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cmp | input | CMP_W (2) | Comparator selected for the write |
| cfg_field | input | 2 | Field code: 0 control, 1 address, 2 data, 3 mask |
| cfg_wdata | input | REG_W (16) | Write data |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_data | input | DATA_W (16) | Bus data |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| match | output | N_CMP (4) | Registered match pulse per comparator |

## Verification
The bench uses the default parameters: two pairs, 16-bit address and 16-bit data. With these widths it can aim addresses directly at the bounds and one step beyond them on both sides. It can also give every data byte a distinct value, so mask edges are exercised. Having two pairs means one pair can run inside mode while the other runs outside mode, and each partner keeps its own exact compare at the same time. A pseudo-random phase then draws addresses from near the configured values and mixes directions and sizes.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    typedef enum logic [1:0] {
        DIR_ANY    = 2'd0,
        DIR_READ   = 2'd1,
        DIR_WRITE  = 2'd2,
        DIR_EITHER = 2'd3
    } wpt_dir_e;

    typedef enum logic [1:0] {
        MODE_EXACT   = 2'd0,
        MODE_INSIDE  = 2'd1,
        MODE_OUTSIDE = 2'd2,
        MODE_EXACT2  = 2'd3
    } wpt_mode_e;

    typedef enum logic [1:0] {
        SZ_ANY   = 2'd0,
        SZ_BYTE  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_ANY2  = 2'd3
    } wpt_size_e;

    typedef enum logic [1:0] {
        FLD_CTL  = 2'd0,
        FLD_ADDR = 2'd1,
        FLD_DATA = 2'd2,
        FLD_MASK = 2'd3
    } wpt_field_e;

    // control word, bit 0 at the bottom
    typedef struct packed {
        wpt_size_e size;  // [6:5]
        wpt_mode_e mode;  // [4:3]
        wpt_dir_e  dir;   // [2:1]
        logic      en;    // [0]
    } wpt_ctl_t;

    localparam int CTL_W = $bits(wpt_ctl_t);

endpackage

// File: rtl/wpt_cfg.sv
module wpt_cfg
    import wpt_pkg::*;
#(
    parameter int N_CMP  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int REG_W  = 16,
    parameter int CMP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CMP_W-1:0]  cfg_cmp,
    input  logic [1:0]        cfg_field,
    input  logic [REG_W-1:0]  cfg_wdata,
    output wpt_ctl_t          ctl      [N_CMP],
    output logic [ADDR_W-1:0] addr_val [N_CMP],
    output logic [DATA_W-1:0] data_val [N_CMP],
    output logic [DATA_W-1:0] data_msk [N_CMP]
);

    wpt_field_e fld;
    assign fld = wpt_field_e'(cfg_field);

    for (genvar k = 0; k < N_CMP; k++) begin : g_slot
        logic sel;
        assign sel = cfg_we && (cfg_cmp == CMP_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl[k]      <= '0;
                addr_val[k] <= '0;
            end else if (sel) begin
                if (fld == FLD_CTL)  ctl[k]      <= wpt_ctl_t'(cfg_wdata[CTL_W-1:0]);
                if (fld == FLD_ADDR) addr_val[k] <= cfg_wdata[ADDR_W-1:0];
            end
        end

        if ((k % 2) == 0) begin : g_full
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    data_val[k] <= '0;
                    data_msk[k] <= '0;
                end else if (sel) begin
                    if (fld == FLD_DATA) data_val[k] <= cfg_wdata[DATA_W-1:0];
                    if (fld == FLD_MASK) data_msk[k] <= cfg_wdata[DATA_W-1:0];
                end
            end
        end else begin : g_addr_only
            assign data_val[k] = '0;
            assign data_msk[k] = '0;
        end
    end

endmodule

// File: rtl/wpt_cmp.sv
module wpt_cmp
    import wpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter bit FULL   = 1'b1
) (
    input  wpt_ctl_t          ctl,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] max_addr,
    input  logic [DATA_W-1:0] data_val,
    input  logic [DATA_W-1:0] data_msk,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rnw,
    input  logic              bus_byte,
    output logic              hit
);

    logic dir_ok;
    logic qual;

    always_comb begin
        unique case (ctl.dir)
            DIR_READ:  dir_ok = bus_rnw;
            DIR_WRITE: dir_ok = !bus_rnw;
            default:   dir_ok = 1'b1;
        endcase
    end

    assign qual = bus_valid && ctl.en && dir_ok;

    if (FULL) begin : g_full
        logic in_span;
        logic data_ok;
        assign in_span = (bus_addr >= own_addr) && (bus_addr <= max_addr);
        assign data_ok = ((bus_data ^ data_val) & data_msk) == '0;

        always_comb begin
            unique case (ctl.mode)
                MODE_INSIDE:  hit = qual && in_span;
                MODE_OUTSIDE: hit = qual && !in_span;
                default:      hit = qual && (bus_addr == own_addr) && data_ok;
            endcase
        end
    end else begin : g_addr
        logic size_ok;
        always_comb begin
            unique case (ctl.size)
                SZ_BYTE: size_ok = bus_byte;
                SZ_WORD: size_ok = !bus_byte;
                default: size_ok = 1'b1;
            endcase
        end
        assign hit = qual && size_ok && (bus_addr == own_addr);
    end

endmodule

// File: rtl/wpt_bank.sv
module wpt_bank
    import wpt_pkg::*;
#(
    parameter int N_PAIRS = 2,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    localparam int N_CMP  = 2 * N_PAIRS,
    localparam int CMP_W  = (N_CMP > 1) ? $clog2(N_CMP) : 1,
    localparam int WID_AD = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
    localparam int REG_W  = (WID_AD > CTL_W) ? WID_AD : CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CMP_W-1:0]  cfg_cmp,
    input  logic [1:0]        cfg_field,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rnw,
    input  logic              bus_byte,
    output logic [N_CMP-1:0]  match
);

    wpt_ctl_t          ctl      [N_CMP];
    logic [ADDR_W-1:0] addr_val [N_CMP];
    logic [DATA_W-1:0] data_val [N_CMP];
    logic [DATA_W-1:0] data_msk [N_CMP];
    logic [N_CMP-1:0]  hit;

    wpt_cfg #(
        .N_CMP(N_CMP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .REG_W(REG_W), .CMP_W(CMP_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cmp(cfg_cmp),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .ctl(ctl), .addr_val(addr_val), .data_val(data_val), .data_msk(data_msk)
    );

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        localparam int LO = 2 * p;
        localparam int HI = 2 * p + 1;

        wpt_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FULL(1'b1)) u_lo (
            .ctl(ctl[LO]), .own_addr(addr_val[LO]), .max_addr(addr_val[HI]),
            .data_val(data_val[LO]), .data_msk(data_msk[LO]),
            .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
            .bus_rnw(bus_rnw), .bus_byte(bus_byte), .hit(hit[LO])
        );

        wpt_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FULL(1'b0)) u_hi (
            .ctl(ctl[HI]), .own_addr(addr_val[HI]), .max_addr(addr_val[HI]),
            .data_val(data_val[HI]), .data_msk(data_msk[HI]),
            .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
            .bus_rnw(bus_rnw), .bus_byte(bus_byte), .hit(hit[HI])
        );

        // range bounds on the full comparator's line
        assert_inside_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && ctl[LO].mode == MODE_INSIDE &&
             (bus_addr < addr_val[LO] || bus_addr > addr_val[HI])) |=> !match[LO]);

        assert_outside_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && ctl[LO].mode == MODE_OUTSIDE &&
             bus_addr >= addr_val[LO] && bus_addr <= addr_val[HI]) |=> !match[LO]);

        assert_byte_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[HI].size == SZ_BYTE && !bus_byte) |=> !match[HI]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match <= '0;
        else        match <= hit;
    end

    assert_idle_no_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (match == '0));

    for (genvar k = 0; k < N_CMP; k++) begin : g_chk
        assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl[k].en |=> !match[k]);

        assert_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && ctl[k].dir == DIR_READ && !bus_rnw) |=> !match[k]);
    end

endmodule

// File: tb/wpt_bank_test.sv
module wpt_bank_test;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_cmp = '0;
    logic [1:0]    cfg_field = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic          bus_rnw = 1'b0;
    logic          bus_byte = 1'b0;
    logic [NC-1:0] match;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [NC-1:0] exp_q[$];
    string         tag_q[$];

    // bench-side configuration mirror
    logic [6:0]    m_ctl  [NC];
    logic [AW-1:0] m_addr [NC];
    logic [DW-1:0] m_data [NC];
    logic [DW-1:0] m_mask [NC];

    wpt_bank uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cmp(cfg_cmp),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_rnw(bus_rnw),
        .bus_byte(bus_byte), .match(match)
    );

    always #2 clk = ~clk;

    function automatic logic [NC-1:0] model(input logic v, input logic [AW-1:0] a,
                                            input logic [DW-1:0] d, input logic rnw,
                                            input logic byt);
        logic [NC-1:0] e;
        for (int k = 0; k < NC; k++) begin
            logic en, dok, sok, r, inr;
            logic [1:0] dir, mode, size;
            en   = m_ctl[k][0];
            dir  = m_ctl[k][2:1];
            mode = m_ctl[k][4:3];
            size = m_ctl[k][6:5];
            dok  = (dir == 2'd1) ? rnw : (dir == 2'd2) ? !rnw : 1'b1;
            if ((k % 2) == 0) begin
                inr = (a >= m_addr[k]) && (a <= m_addr[k+1]);
                if (mode == 2'd1)      r = inr;
                else if (mode == 2'd2) r = !inr;
                else r = (a == m_addr[k]) && (((d ^ m_data[k]) & m_mask[k]) == '0);
            end else begin
                sok = (size == 2'd1) ? byt : (size == 2'd2) ? !byt : 1'b1;
                r = (a == m_addr[k]) && sok;
            end
            e[k] = v && en && dok && r;
        end
        return e;
    endfunction

    task automatic bus(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic rnw, input logic byt, input string tag);
        @(negedge clk);
        cfg_we = 1'b0;
        bus_valid = v; bus_addr = a; bus_data = d; bus_rnw = rnw; bus_byte = byt;
        exp_q.push_back(model(v, a, d, rnw, byt));
        tag_q.push_back(tag);
    endtask

    // R10 write port; bus idle in the write cycle
    task automatic wr(input int c, input int f, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cmp = 2'(c); cfg_field = 2'(f); cfg_wdata = val;
        bus_valid = 1'b0;
        exp_q.push_back('0);
        tag_q.push_back("R10");
        case (f)
            0: m_ctl[c]  = val[6:0];
            1: m_addr[c] = val;
            2: m_data[c] = val;
            default: m_mask[c] = val;
        endcase
    endtask

    function automatic logic [15:0] ctlw(input int en, input int dir, input int mode, input int size);
        return 16'((size << 5) | (mode << 3) | (dir << 1) | en);
    endfunction

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [NC-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (match !== e) begin
                n_fail++;
                $display("FAIL %s: match actual=%b expected=%b", t, match, e);
            end
        end
    end

    initial begin
        for (int k = 0; k < NC; k++) begin
            m_ctl[k] = '0; m_addr[k] = '0; m_data[k] = '0; m_mask[k] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (match !== '0) begin
            n_fail++;
            $display("FAIL R1: match in reset actual=%b expected=0000", match);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: disabled after reset, even address 0 with data 0 gives nothing
        bus(1, 16'h0000, 16'h0000, 1, 0, "R1");
        bus(1, 16'h0000, 16'h0000, 0, 1, "R1");

        // R4/R10: comparator 0 exact, upper data byte compared
        wr(0, 1, 16'h1234); wr(0, 2, 16'hAB00); wr(0, 3, 16'hFF00);
        wr(0, 0, ctlw(1, 0, 0, 0));
        bus(1, 16'h1234, 16'hABCD, 1, 0, "R4");
        bus(1, 16'h1234, 16'hAC00, 1, 0, "R4");
        bus(1, 16'h1235, 16'hAB00, 0, 0, "R4");
        bus(1, 16'h1234, 16'hAB77, 0, 0, "R4");
        // R7: full comparator ignores bus_byte
        bus(1, 16'h1234, 16'hAB00, 0, 1, "R7");
        // R2: invalid cycle, then single pulse
        bus(0, 16'h1234, 16'hAB00, 1, 0, "R2");
        bus(1, 16'h1234, 16'hAB00, 1, 0, "R2");
        bus(1, 16'h0001, 16'hAB00, 1, 0, "R2");

        // R5: comparator 1 address only
        wr(1, 2, 16'h5555);
        wr(1, 1, 16'h2000); wr(1, 0, ctlw(1, 0, 0, 0));
        bus(1, 16'h2000, 16'h0000, 1, 0, "R5");
        bus(1, 16'h2000, 16'hFFFF, 0, 1, "R5");
        bus(1, 16'h2001, 16'h5555, 0, 1, "R5");

        // R6: comparator 2 reads only, then writes only
        wr(2, 1, 16'h3000); wr(2, 3, 16'h0000); wr(2, 0, ctlw(1, 1, 0, 0));
        bus(1, 16'h3000, 16'h1111, 0, 0, "R6");
        bus(1, 16'h3000, 16'h1111, 1, 0, "R6");
        wr(2, 0, ctlw(1, 2, 0, 0));
        bus(1, 16'h3000, 16'h1111, 1, 0, "R6");
        bus(1, 16'h3000, 16'h1111, 0, 0, "R6");

        // R7: comparator 3 byte only, then word only
        wr(3, 1, 16'h3002); wr(3, 0, ctlw(1, 0, 0, 1));
        bus(1, 16'h3002, 16'h0, 1, 0, "R7");
        bus(1, 16'h3002, 16'h0, 1, 1, "R7");
        wr(3, 0, ctlw(1, 0, 0, 2));
        bus(1, 16'h3002, 16'h0, 1, 1, "R7");
        bus(1, 16'h3002, 16'h0, 1, 0, "R7");

        // R8/R11: pair 0 inside [1000,10FF], comparator 1 exact at 10FF
        wr(0, 1, 16'h1000); wr(1, 1, 16'h10FF); wr(0, 0, ctlw(1, 0, 1, 0));
        bus(1, 16'h0FFF, 16'h0, 1, 0, "R8");
        bus(1, 16'h1000, 16'h0, 1, 0, "R8");
        bus(1, 16'h1080, 16'h0, 0, 1, "R8");
        bus(1, 16'h10FF, 16'h0, 1, 0, "R11");
        bus(1, 16'h1100, 16'h0, 1, 0, "R8");

        // R9: pair 1 outside [4000,4010]
        wr(2, 1, 16'h4000); wr(3, 1, 16'h4010);
        wr(3, 0, ctlw(1, 0, 0, 0)); wr(2, 0, ctlw(1, 0, 2, 0));
        bus(1, 16'h3FFF, 16'h0, 1, 0, "R9");
        bus(1, 16'h4000, 16'h0, 1, 0, "R9");
        bus(1, 16'h4010, 16'h0, 0, 0, "R11");
        bus(1, 16'h4011, 16'h0, 0, 0, "R9");

        // mixed pseudo-random traffic around the configured values
        begin
            logic [31:0] s;
            logic [15:0] pool [8];
            s = 32'h1234_5678;
            pool[0] = 16'h0FFF; pool[1] = 16'h1000; pool[2] = 16'h10FF; pool[3] = 16'h1100;
            pool[4] = 16'h3FFF; pool[5] = 16'h4000; pool[6] = 16'h4010; pool[7] = 16'h4011;
            for (int i = 0; i < 200; i++) begin
                s = s * 32'd1664525 + 32'd1013904223;
                bus(s[31], pool[s[26:24]], s[15:0], s[20], s[21], "R8");
            end
        end

        // R3: disable comparator 0 and 3
        wr(0, 0, ctlw(0, 0, 1, 0)); wr(3, 0, ctlw(0, 0, 0, 0));
        bus(1, 16'h1050, 16'h0, 1, 0, "R3");
        bus(1, 16'h4010, 16'h0, 1, 0, "R3");

        bus(0, 16'h0, 16'h0, 0, 0, "R2");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule